// File: doc/BRIEF.md
# Latched Instrument Status Register Group

This block gathers fault and operating-mode indications from a programmable load into a 16-bit status structure with three layers. The condition layer shows the live state of each indication. The event layer captures each condition's rising edge and holds it until software reads it or a clear-all strobe arrives. The enable layer masks which captured events count toward one summary bit, and that bit feeds a higher-level status byte.

Several indications share one voltage-fault bit. Remote reverse voltage, local reverse voltage and overvoltage each set it. It does not follow their release and clears only on a clear-all strobe or a reset. Overvoltage also drives an output that switches off the load input. A small register port selects a layer, reads it and writes the enable mask. Reading the event layer clears it.

At reset, the enable mask is either cleared or loaded from a retained value. A power-on-clear flag chooses between the two.

Top module: `qstat_group`

## Requirements
- R1: The condition layer places its bits as follows: voltage fault at bit 0, overpower at bit 3, list running at bit 7, remote reverse voltage at bit 9, unregulated at bit 10, local reverse voltage at bit 11, overvoltage at bit 12, protection shutdown at bit 13 and sink-on at bit 14. All other bits are 0. The layer is read with `reg_sel` = 0.
- R2: Every unassigned bit (1, 2, 4, 5, 6, 8 and 15) reads as 0 in the condition, event and enable layers, whatever value is written. A read with `reg_sel` = 3 returns 0.
- R3: Remote or local reverse voltage sets its own condition bit and the voltage-fault bit. On release, only its own bit clears.
- R4: Overvoltage sets condition bits 12 and 0, and `load_off` is 1 while the overvoltage input is 1.
- R5: The unregulated condition bit follows its input, set and clear.
- R6: An event bit becomes 1 at the clock edge that closes the first cycle in which its condition bit is 1 after having been 0. It stays 1 while the condition is held, toggles or falls, until it is cleared.
- R7: A read of the event layer (`reg_sel` = 1, `rd_en` = 1) returns the latched value and clears the layer at that clock edge. A condition rising edge in the same cycle leaves its event bit set.
- R8: The event layer is read-only. A write with `reg_sel` = 1 or 0 changes no layer.
- R9: A write with `reg_sel` = 2 loads the enable layer, and a read with `reg_sel` = 2 returns it. The `preset` strobe clears it and takes priority over a write.
- R10: While reset is active, the enable layer becomes 0 if `por_clear` is 1. Otherwise it becomes `en_retain` with the unassigned bits masked.
- R11: `summary` is 1 exactly when some event bit and its matching enable bit are both 1.
- R12: The voltage-fault condition bit stays 1 after its sources are released. Only `clear_all` or reset clears it, and after either one it returns only if a source is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_clear | input | 1 | Selects whether reset clears the enable layer |
| en_retain | input | 16 | Enable value kept across reset when `por_clear` is 0 |
| remote_rv | input | 1 | Reverse voltage at the sense terminals |
| local_rv | input | 1 | Reverse voltage at the input terminals |
| over_volt | input | 1 | Overvoltage condition |
| over_power | input | 1 | Overpower condition |
| list_run | input | 1 | Sequenced list mode running |
| unreg | input | 1 | Input unregulated |
| prot_shut | input | 1 | Protection shutdown active |
| sink_on | input | 1 | Input above turn-on voltage, sinking current |
| clear_all | input | 1 | Clears the event layer and the sticky voltage fault |
| preset | input | 1 | Clears the enable layer |
| reg_sel | input | 2 | Layer select: 0 condition, 1 event, 2 enable, 3 none |
| rd_en | input | 1 | Read strobe; clears the event layer when `reg_sel` = 1 |
| wr_en | input | 1 | Write strobe; takes effect only when `reg_sel` = 2 |
| wr_data | input | 16 | Write data for the enable layer |
| rd_data | output | 16 | Combinational read data of the selected layer |
| summary | output | 1 | Masked OR of the event layer |
| load_off | output | 1 | Request to switch off the load input |

## Verification
The assertions assume the strobes are synchronous to `clk` and that a condition input holds a stable level for the whole clock cycle. They also assume reset is released only while `clear_all` and `preset` are low. The stimulus changes every input one time unit after a rising edge and pulses each strobe for exactly one cycle. It releases reset with every strobe low, so each captured rising edge corresponds to one intended transition.

// File: rtl/qstat_pkg.sv
package qstat_pkg;
  localparam int W = 16;

  localparam int BIT_VFLT   = 0;
  localparam int BIT_OVPWR  = 3;
  localparam int BIT_LIST   = 7;
  localparam int BIT_REMREV = 9;
  localparam int BIT_UNREG  = 10;
  localparam int BIT_LOCREV = 11;
  localparam int BIT_OVOLT  = 12;
  localparam int BIT_SHUT   = 13;
  localparam int BIT_SINK   = 14;

  localparam logic [W-1:0] VALID_MASK =
      (W'(1) << BIT_VFLT)   | (W'(1) << BIT_OVPWR) | (W'(1) << BIT_LIST)  |
      (W'(1) << BIT_REMREV) | (W'(1) << BIT_UNREG) | (W'(1) << BIT_LOCREV) |
      (W'(1) << BIT_OVOLT)  | (W'(1) << BIT_SHUT)  | (W'(1) << BIT_SINK);

  typedef enum logic [1:0] {
    SEL_COND   = 2'd0,
    SEL_EVENT  = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_NONE   = 2'd3
  } sel_e;
endpackage

// File: rtl/qstat_cond.sv
module qstat_cond
  import qstat_pkg::*;
#(
  parameter int WIDTH = W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             remote_rv,
  input  logic             local_rv,
  input  logic             over_volt,
  input  logic             over_power,
  input  logic             list_run,
  input  logic             unreg,
  input  logic             prot_shut,
  input  logic             sink_on,
  input  logic             clear_all,
  output logic [WIDTH-1:0] cond,
  output logic             load_off
);
  logic vf_src;
  logic vf_q, vf_d;

  assign vf_src = remote_rv | local_rv | over_volt;

  always_comb begin
    vf_d = vf_src | (vf_q & ~clear_all);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vf_q <= 1'b0;
    else        vf_q <= vf_d;
  end

  always_comb begin
    cond             = '0;
    cond[BIT_VFLT]   = vf_src | vf_q;
    cond[BIT_OVPWR]  = over_power;
    cond[BIT_LIST]   = list_run;
    cond[BIT_REMREV] = remote_rv;
    cond[BIT_UNREG]  = unreg;
    cond[BIT_LOCREV] = local_rv;
    cond[BIT_OVOLT]  = over_volt;
    cond[BIT_SHUT]   = prot_shut;
    cond[BIT_SINK]   = sink_on;
  end

  assign load_off = over_volt;

  // R12
  vf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vf_q && !clear_all) |=> vf_q);

  // R3
  vf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (remote_rv || local_rv || over_volt) |=> vf_q);
endmodule

// File: rtl/qstat_event.sv
module qstat_event
  import qstat_pkg::*;
#(
  parameter int WIDTH = W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cond,
  input  logic             clr,
  output logic [WIDTH-1:0] ev
);
  localparam logic [WIDTH-1:0] MASK = WIDTH'(VALID_MASK);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] ev_q, ev_d;
  logic [WIDTH-1:0] rise;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (MASK[i]) begin : g_live
      assign rise[i] = cond[i] & ~prev_q[i];
      always_comb ev_d[i] = rise[i] | (ev_q[i] & ~clr);
    end else begin : g_tied
      assign rise[i] = 1'b0;
      always_comb ev_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      ev_q   <= '0;
    end else begin
      prev_q <= cond & MASK;
      ev_q   <= ev_d;
    end
  end

  assign ev = ev_q;

  // R2
  ev_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q & ~MASK) == '0);

  // R6
  ev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((ev_q & $past(ev_q)) == $past(ev_q)));
endmodule

// File: rtl/qstat_enable.sv
module qstat_enable
  import qstat_pkg::*;
#(
  parameter int WIDTH = W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_clear,
  input  logic [WIDTH-1:0] en_retain,
  input  logic             preset,
  input  logic             wr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] en
);
  localparam logic [WIDTH-1:0] MASK = WIDTH'(VALID_MASK);

  logic [WIDTH-1:0] en_q, en_d;
  logic             en_ce;

  always_comb begin
    en_ce = preset | wr;
    en_d  = preset ? '0 : (wr_data & MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= por_clear ? '0 : (en_retain & MASK);
    else if (en_ce) en_q <= en_d;
  end

  assign en = en_q;

  // R9
  preset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (en_q == '0));

  // R2
  en_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~MASK) == '0);
endmodule

// File: rtl/qstat_group.sv
module qstat_group
  import qstat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_clear,
  input  logic [15:0] en_retain,
  input  logic        remote_rv,
  input  logic        local_rv,
  input  logic        over_volt,
  input  logic        over_power,
  input  logic        list_run,
  input  logic        unreg,
  input  logic        prot_shut,
  input  logic        sink_on,
  input  logic        clear_all,
  input  logic        preset,
  input  logic [1:0]  reg_sel,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        summary,
  output logic        load_off
);
  logic [W-1:0] cond, ev, en;
  logic         ev_clr;
  logic         en_wr;
  sel_e         sel;

  assign sel    = sel_e'(reg_sel);
  assign ev_clr = clear_all | (rd_en & (sel == SEL_EVENT));
  assign en_wr  = wr_en & (sel == SEL_ENABLE);

  qstat_cond #(.WIDTH(W)) u_cond (
    .clk(clk), .rst_n(rst_n),
    .remote_rv(remote_rv), .local_rv(local_rv), .over_volt(over_volt),
    .over_power(over_power), .list_run(list_run), .unreg(unreg),
    .prot_shut(prot_shut), .sink_on(sink_on), .clear_all(clear_all),
    .cond(cond), .load_off(load_off)
  );

  qstat_event #(.WIDTH(W)) u_event (
    .clk(clk), .rst_n(rst_n), .cond(cond), .clr(ev_clr), .ev(ev)
  );

  qstat_enable #(.WIDTH(W)) u_enable (
    .clk(clk), .rst_n(rst_n), .por_clear(por_clear), .en_retain(en_retain),
    .preset(preset), .wr(en_wr), .wr_data(wr_data), .en(en)
  );

  always_comb begin
    case (sel)
      SEL_COND:   rd_data = cond;
      SEL_EVENT:  rd_data = ev;
      SEL_ENABLE: rd_data = en;
      default:    rd_data = '0;
    endcase
  end

  assign summary = |(ev & en);

  // R11
  summary_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> !summary);
endmodule

// File: tb/qstat_group_tb.sv
module qstat_group_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        por_clear;
  logic [15:0] en_retain;
  logic        remote_rv, local_rv, over_volt, over_power, list_run;
  logic        unreg, prot_shut, sink_on, clear_all, preset;
  logic [1:0]  reg_sel;
  logic        rd_en, wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        summary, load_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  localparam logic [15:0] ALL_VALID = 16'h7E89;

  always #4 clk = ~clk;

  qstat_group u_dut (
    .clk(clk), .rst_n(rst_n), .por_clear(por_clear), .en_retain(en_retain),
    .remote_rv(remote_rv), .local_rv(local_rv), .over_volt(over_volt),
    .over_power(over_power), .list_run(list_run), .unreg(unreg),
    .prot_shut(prot_shut), .sink_on(sink_on), .clear_all(clear_all),
    .preset(preset), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .summary(summary),
    .load_off(load_off)
  );

  // Monitor: compares each read against the scoreboard entry queued by the driver.
  always @(negedge clk) begin
    if (rst_n && rd_en && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        fails++;
        $display("FAIL %s: rd_data actual=%h expected=%h", t, rd_data, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [15:0] e, input string t);
    reg_sel = sel;
    rd_en   = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    tick();
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    reg_sel = sel;
    wr_en   = 1'b1;
    wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", t, act, e);
    end
  endtask

  task automatic do_reset(input logic pc, input logic [15:0] ret);
    por_clear = pc;
    en_retain = ret;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    {remote_rv, local_rv, over_volt, over_power, list_run} = '0;
    {unreg, prot_shut, sink_on, clear_all, preset} = '0;
    reg_sel = 2'd0; rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    rst_n = 1'b0; por_clear = 1'b0; en_retain = '0;

    // R10 retained enable value, unassigned bits masked
    do_reset(1'b0, 16'hABCD);
    rd(2'd2, 16'h2A89, "R10 retained enable");
    rd(2'd0, 16'h0000, "R1 reset condition");
    rd(2'd1, 16'h0000, "R6 reset event");
    chk(summary, 1'b0, "R11 reset summary");

    // R9 / R2 enable write
    wr(2'd2, 16'hFFFF);
    rd(2'd2, ALL_VALID, "R9 R2 enable write masks unassigned bits");

    // R3 remote reverse voltage
    remote_rv = 1'b1;
    rd(2'd0, 16'h0201, "R3 remote reverse sets own and fault bits");
    remote_rv = 1'b0;
    rd(2'd0, 16'h0001, "R3 R12 fault bit sticky after remote release");
    chk(summary, 1'b1, "R11 summary with enabled event");
    rd(2'd1, 16'h0201, "R6 R7 event latched");
    rd(2'd1, 16'h0000, "R7 event cleared by read");
    chk(summary, 1'b0, "R11 summary after read clear");

    // R8 event layer read-only
    local_rv = 1'b1;
    tick();
    local_rv = 1'b0;
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'hFFFF);
    rd(2'd1, 16'h0800, "R8 R3 writes ignored, local reverse event kept");
    rd(2'd2, ALL_VALID, "R8 enable untouched by other writes");
    rd(2'd0, 16'h0001, "R3 fault bit sticky after local release");
    rd(2'd1, 16'h0000, "R7 event cleared");

    // R12 clear_all
    clear_all = 1'b1;
    tick();
    clear_all = 1'b0;
    rd(2'd0, 16'h0000, "R12 clear_all drops fault bit");

    // R4 overvoltage
    over_volt = 1'b1;
    chk(load_off, 1'b1, "R4 load_off during overvoltage");
    rd(2'd0, 16'h1001, "R4 overvoltage condition");
    over_volt = 1'b0;
    chk(load_off, 1'b0, "R4 load_off released");
    rd(2'd1, 16'h1001, "R4 R6 overvoltage events");
    rd(2'd0, 16'h0001, "R12 fault stays after overvoltage");

    // R5 unregulated follows input
    unreg = 1'b1;
    rd(2'd0, 16'h0401, "R5 unregulated set");
    unreg = 1'b0;
    rd(2'd0, 16'h0001, "R5 unregulated cleared");
    rd(2'd1, 16'h0400, "R5 R6 unregulated event held");

    // R1 remaining positions, R6 no retrigger while held
    over_power = 1'b1; list_run = 1'b1; prot_shut = 1'b1; sink_on = 1'b1;
    rd(2'd0, 16'h6089, "R1 bit positions");
    rd(2'd1, 16'h6088, "R6 rising events captured");
    rd(2'd1, 16'h0000, "R6 held conditions do not retrigger");

    // R7 rising edge in the same cycle as a read-clear
    over_power = 1'b0;
    tick();
    over_power = 1'b1;
    rd(2'd1, 16'h0000, "R7 read during new edge");
    rd(2'd1, 16'h0008, "R7 new edge survives clear");

    // R11 masking
    list_run = 1'b0;
    tick();
    list_run = 1'b1;
    tick();
    wr(2'd2, 16'h0008);
    chk(summary, 1'b0, "R11 masked event");
    wr(2'd2, 16'h0080);
    chk(summary, 1'b1, "R11 enabled event");

    // R9 preset, priority over a write
    reg_sel = 2'd2; wr_en = 1'b1; wr_data = 16'hFFFF; preset = 1'b1;
    tick();
    wr_en = 1'b0; preset = 1'b0;
    chk(summary, 1'b0, "R9 R11 preset clears summary");
    rd(2'd2, 16'h0000, "R9 preset beats write");
    rd(2'd3, 16'h0000, "R2 unused select reads zero");

    // R10 power-on clear, R12 reset drops fault
    do_reset(1'b1, 16'hFFFF);
    rd(2'd2, 16'h0000, "R10 power-on clear");
    rd(2'd0, 16'h6088, "R12 reset drops fault bit");

    tick();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule